// File: doc/BRIEF.md
# DMA Interrupt Status Register

This block keeps the event and summary status of a descriptor-driven DMA engine inside a storage-card host controller. It collects single-cycle pulses from the DMA core and from the card interface and holds each one in a sticky status bit. It folds the enabled bits into two summary flags, one for normal completion and one for abnormal conditions. When a fatal bus error occurs, it latches the cause code and holds a bus-block output high.

Software reads a 32-bit status word and clears bits by writing ones to their positions. The same word also shows the live state code of the DMA sequencer. The interrupt line is high while either summary flag is set. A per-source enable vector picks which status bits may feed the summaries. In that vector, bit 0 is transmit, bit 1 is receive, bit 2 is fatal bus error and bit 3 is descriptor unavailable, and 1 means enabled.

Top module: `dma_irq_status`

## Requirements
- R1: After reset every stored status bit reads 0, and `irq` and `bus_block` are low.
- R2: One clock after each event pulse, its bit reads 1: `ev_tx_done` sets bit 0, `ev_rx_done` sets bit 1, `ev_bus_fault` sets bit 2. A descriptor fetch strobe sets bit 4 only when the fetched ownership bit is 0; with ownership 1 it has no effect.
- R3: Bit 5 is set one clock after any one of the seven card error flags pulses.
- R4: Writing a 1 to bit 0, 1, 2, 4, 5, 8 or 9 clears that bit. Writing 0 leaves it unchanged.
- R5: An event arriving in the same cycle as a write-one clear of its bit leaves the bit set.
- R6: Bit 8 is set whenever bit 0 or bit 1 is set with its enable at 1. It stays set after those sources are cleared, until bit 8 itself is written with 1. A source whose enable is 0 never sets it.
- R7: Bit 9 behaves the same way for bits 2 and 4 under enables 2 and 3.
- R8: A fatal bus error latches `ev_fault_code` into bits 12:10. The value 3'b001 means a host abort during transmit and 3'b010 means one during receive. These bits read 0 whenever bit 2 is clear. The code sets no summary bit.
- R9: `bus_block` is high exactly while bit 2 is set.
- R10: Bits 16:13 show `dma_state` (0 idle up to 8 descriptor close). Writes to those bits are ignored.
- R11: Bits 3, 6, 7 and 31:17 always read 0. Writes to them are ignored.
- R12: `irq` equals bit 8 OR bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_tx_done | input | 1 | Transmit descriptor done pulse |
| ev_rx_done | input | 1 | Receive descriptor done pulse |
| ev_bus_fault | input | 1 | Fatal bus error pulse |
| ev_fault_code | input | 3 | Cause code qualified by `ev_bus_fault` |
| ev_desc_fetch | input | 1 | Descriptor first word fetched |
| desc_owner | input | 1 | Ownership bit of the fetched descriptor |
| card_err | input | CARD_ERR_W | Card error flag pulses |
| int_en | input | 4 | Per-source summary enables |
| dma_state | input | STATE_W | Current DMA sequencer state code |
| wr_en | input | 1 | Status write strobe |
| wr_data | input | 32 | Write-one-to-clear data |
| rd_data | output | 32 | Status word |
| bus_block | output | 1 | Blocks DMA bus accesses |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default seven card error flags and a four-bit state field. With this size, every one of the 16 enable vectors can be combined with each of the four summary sources. Each card flag can be tried alone, and all 16 state codes can be swept. The bench covers the sticky summary sequence of setting, clearing the source and then clearing the summary. It also covers a clear and an event colliding in the same cycle, both fault codes, and a descriptor with its ownership bit set.

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int CARD_ERR_W = 7,
  parameter int STATE_W    = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev_tx_done,
  input  logic                  ev_rx_done,
  input  logic                  ev_bus_fault,
  input  logic [2:0]            ev_fault_code,
  input  logic                  ev_desc_fetch,
  input  logic                  desc_owner,
  input  logic [CARD_ERR_W-1:0] card_err,
  input  logic [3:0]            int_en,
  input  logic [STATE_W-1:0]    dma_state,
  input  logic                  wr_en,
  input  logic [31:0]           wr_data,
  output logic [31:0]           rd_data,
  output logic                  bus_block,
  output logic                  irq
);
  localparam int STATE_LSB = 13;

  logic tx_q, rx_q, flt_q, du_q, card_q, nrm_q, abn_q;
  logic [2:0] code_q;
  logic tx_d, rx_d, flt_d, du_d, card_d, nrm_d, abn_d;
  logic [2:0] code_d;
  logic [31:0] clr;

  assign clr = wr_en ? wr_data : 32'd0;

  assign tx_d   = (tx_q   & ~clr[0]) | ev_tx_done;
  assign rx_d   = (rx_q   & ~clr[1]) | ev_rx_done;
  assign flt_d  = (flt_q  & ~clr[2]) | ev_bus_fault;
  assign du_d   = (du_q   & ~clr[4]) | (ev_desc_fetch & ~desc_owner);
  assign card_d = (card_q & ~clr[5]) | (|card_err);
  assign nrm_d  = (nrm_q  & ~clr[8]) | (tx_d & int_en[0]) | (rx_d & int_en[1]);
  assign abn_d  = (abn_q  & ~clr[9]) | (flt_d & int_en[2]) | (du_d & int_en[3]);
  assign code_d = ev_bus_fault ? ev_fault_code : (flt_d ? code_q : 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= 1'b0;
      rx_q   <= 1'b0;
      flt_q  <= 1'b0;
      du_q   <= 1'b0;
      card_q <= 1'b0;
      nrm_q  <= 1'b0;
      abn_q  <= 1'b0;
      code_q <= 3'd0;
    end else begin
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      flt_q  <= flt_d;
      du_q   <= du_d;
      card_q <= card_d;
      nrm_q  <= nrm_d;
      abn_q  <= abn_d;
      code_q <= code_d;
    end
  end

  always_comb begin
    rd_data = 32'd0;
    rd_data[0] = tx_q;
    rd_data[1] = rx_q;
    rd_data[2] = flt_q;
    rd_data[4] = du_q;
    rd_data[5] = card_q;
    rd_data[8] = nrm_q;
    rd_data[9] = abn_q;
    rd_data[12:10] = code_q;
    rd_data[STATE_LSB +: STATE_W] = dma_state;
  end

  assign bus_block = flt_q;
  assign irq       = nrm_q | abn_q;
endmodule

module dma_irq_status_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ev_tx_done,
  input logic        ev_bus_fault,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        bus_block,
  input logic        irq
);
  AST_TX_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_done |=> rd_data[0]); // R5
  AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0] && !ev_tx_done) |=> !rd_data[0]); // R4
  AST_FAULT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_fault |=> bus_block); // R9
  AST_NRM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[8] && !(wr_en && wr_data[8])) |=> rd_data[8]); // R6
  AST_ABN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[9] && !(wr_en && wr_data[9])) |=> rd_data[9]); // R7
  AST_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[2] |-> (rd_data[12:10] == 3'd0)); // R8
  AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[31:17] == 15'd0) && (rd_data[7:6] == 2'd0) && !rd_data[3]); // R11
  AST_IRQ_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (rd_data[8] | rd_data[9])); // R12
endmodule

bind dma_irq_status dma_irq_status_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ev_tx_done(ev_tx_done), .ev_bus_fault(ev_bus_fault),
  .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .bus_block(bus_block), .irq(irq)
);

// File: tb/dma_irq_status_test.sv
module dma_irq_status_test;
  localparam int CLK_PERIOD = 10;
  localparam int CEW = 7;

  logic clk = 0, rst_n = 0;
  logic ev_tx_done = 0, ev_rx_done = 0, ev_bus_fault = 0, ev_desc_fetch = 0, desc_owner = 0;
  logic [2:0] ev_fault_code = 0;
  logic [CEW-1:0] card_err = 0;
  logic [3:0] int_en = 0, dma_state = 0;
  logic wr_en = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic bus_block, irq;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_irq_status #(.CARD_ERR_W(CEW), .STATE_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done),
    .ev_bus_fault(ev_bus_fault), .ev_fault_code(ev_fault_code), .ev_desc_fetch(ev_desc_fetch),
    .desc_owner(desc_owner), .card_err(card_err), .int_en(int_en), .dma_state(dma_state),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .bus_block(bus_block), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    ev_tx_done = 0; ev_rx_done = 0; ev_bus_fault = 0; ev_desc_fetch = 0;
    card_err = 0; wr_en = 0; wr_data = 0;
  endtask

  task automatic wclr(logic [31:0] d);
    wr_en = 1; wr_data = d; step();
  endtask

  function automatic logic [31:0] word(logic [31:0] st);
    return st | ({28'd0, dma_state} << 13);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 status", rd_data, 32'd0);
    chk("R1 outputs", {30'd0, irq, bus_block}, 32'd0);

    // R6 R7 R2 R8 R9 R12: sweep enables against each summary source
    for (int m = 0; m < 16; m++) begin
      for (int s = 0; s < 4; s++) begin
        int pos;
        logic [2:0] code;
        logic [31:0] exp, summ;
        pos = (s == 3) ? 4 : s;
        code = (m[0]) ? 3'b010 : 3'b001;
        int_en = m[3:0];
        case (s)
          0: ev_tx_done = 1;
          1: ev_rx_done = 1;
          2: begin ev_bus_fault = 1; ev_fault_code = code; end
          default: begin ev_desc_fetch = 1; desc_owner = 0; end
        endcase
        step();
        summ = 0;
        if (m[s]) summ = (s < 2) ? 32'h100 : 32'h200;
        exp = (32'd1 << pos) | summ | ((s == 2) ? ({29'd0, code} << 10) : 32'd0);
        chk("R2 R6 R7 R8 set", rd_data, exp);
        chk("R9 bus_block", {31'd0, bus_block}, {31'd0, s == 2});
        chk("R12 irq", {31'd0, irq}, {31'd0, summ != 0});
        wclr(32'd1 << pos);
        chk("R6 R7 R8 sticky after source clear", rd_data, summ);
        wclr(32'h300);
        chk("R6 R7 summary clear", rd_data, 32'd0);
      end
    end

    // R2: owned descriptor does not flag
    int_en = 4'hF;
    ev_desc_fetch = 1; desc_owner = 1; step();
    chk("R2 owner set ignored", rd_data, 32'd0);

    // R3: each card error flag alone
    int_en = 4'h0;
    for (int f = 0; f < CEW; f++) begin
      card_err = CEW'(1) << f; step();
      chk("R3 card flag", rd_data, 32'h20);
      wclr(32'h20);
      chk("R3 card clear", rd_data, 32'd0);
    end

    // R4: write zero no effect
    int_en = 4'hF;
    ev_tx_done = 1; ev_bus_fault = 1; ev_fault_code = 3'b001; card_err = 1; step();
    wclr(32'h0);
    chk("R4 zero write", rd_data, 32'h325 | (32'd1 << 10));
    wclr(32'h325);
    chk("R4 all clear", rd_data, 32'd0);
    chk("R9 released", {31'd0, bus_block}, 32'd0);

    // R5: event and clear in the same cycle
    int_en = 4'h0;
    ev_rx_done = 1; step();
    ev_rx_done = 1; wr_en = 1; wr_data = 32'h2; step();
    chk("R5 event wins", rd_data, 32'h2);
    wclr(32'h2);
    chk("R5 later clear", rd_data, 32'd0);

    // R11 R10: reserved and state bits ignore writes
    dma_state = 4'd0;
    wclr(32'hFFFFFFFF);
    chk("R11 reserved", rd_data, 32'd0);

    // R10: state field sweep
    for (int st = 0; st < 16; st++) begin
      dma_state = st[3:0];
      #1;
      chk("R10 state field", rd_data, word(32'd0));
    end
    dma_state = 4'd8;
    wr_en = 1; wr_data = 32'h1E000; step();
    chk("R10 state write ignored", rd_data, 32'd8 << 13);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule